// File: doc/BRIEF.md
# Serial Port Clock Generation Unit

This block produces the two timing strobes a serial port needs, a transmit clock enable and a receive base clock enable. Both are one-cycle pulses on the system clock, and the block runs entirely in that clock domain. A programmable down-counter works as the baud rate generator. It emits one tick every `divisor + 1` cycles and is reloaded either when it reaches zero or when software writes the low byte of the divisor.

Four clocking modes are held in a small mode state machine: `MODE_ASYNC_NORM`, `MODE_ASYNC_DBL`, `MODE_SYNC_MASTER` and `MODE_SYNC_SLAVE`. Every cycle the register takes the state decoded from the mode inputs. Any state can move to any other state one cycle after the inputs change, and each such transition clears the transmit divide stage.

- In the two asynchronous states the transmit enable is the generator tick divided by 16 or by 8.
- In the master state the tick is divided by 2, and the serial clock pin is driven with a selectable polarity.
- In the slave state the serial clock pin is an input. It is synchronised and edge-detected, and each active edge gives one pulse on both enables.

Top module: `sclk_gen`

## Requirements
- R1: When not in the slave state, `rx_tick` pulses once every `divisor + 1` cycles. It is high on every cycle when `divisor` is 0, and never on two consecutive cycles when `divisor` is nonzero.
- R2: If `div_lo_wr` is high at a clock edge, the counter reloads `divisor` at that edge. The next `rx_tick` then comes exactly `divisor + 1` cycles after that edge.
- R3: In `MODE_ASYNC_NORM`, `MODE_ASYNC_DBL` and `MODE_SYNC_MASTER`, `rx_tick` equals the generator tick with no further division.
- R4: In those same states, `tx_tick` is high on every Nth generator tick: N = 16 in normal asynchronous, 8 in double-speed asynchronous and 2 in master. The count starts from reset or from the last mode transition, and `tx_tick` is never high without `rx_tick`.
- R5: The mode is decoded from the inputs as follows. `sync_mode`=0 selects an asynchronous state, with `dbl_speed`=1 choosing double speed. `sync_mode`=1 with `pin_dir_out`=1 selects master. `sync_mode`=1 with `pin_dir_out`=0 selects slave. The new mode takes effect on the cycle after the inputs change, and the change clears the divide stage.
- R6: In `MODE_SYNC_SLAVE`, `sck_in` passes through two synchronising flops. An active edge of `sck_in` gives a one-cycle pulse on both `rx_tick` and `tx_tick`. The active edge is the rising edge when `clk_pol`=0 and the falling edge when `clk_pol`=1. If `sck_in` changes before clock edge k, the pulse is high in the cycle after edge k+1. The other edge gives no pulse.
- R7: In `MODE_SYNC_MASTER`, `sck_oe`=1 and `sck_out` is `clk_pol` XOR an internal level. That level toggles on every generator tick, and `tx_tick` fires on the tick that returns it to 0.
- R8: In the asynchronous states and the slave state, `sck_oe`=0 and `sck_out` equals `clk_pol`. In the asynchronous states `sck_in` has no effect on any output.
- R9: `rst_n` is a synchronous active-low reset. While it is low, both ticks are 0, the counter loads `divisor`, the divide stage clears and the mode register loads the decoded mode. After release, `sck_out` starts at its idle level `clk_pol`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| divisor | input | 12 | Baud divisor; rate is fclk/(divisor+1) |
| div_lo_wr | input | 1 | Divisor low-byte write strobe; forces a reload |
| sync_mode | input | 1 | 1 selects synchronous clocking |
| dbl_speed | input | 1 | 1 selects double speed in asynchronous mode |
| pin_dir_out | input | 1 | Serial clock pin direction; 1 = output (master) |
| clk_pol | input | 1 | Clock polarity: output idle level and active input edge |
| sck_in | input | 1 | Serial clock pin input |
| sck_out | output | 1 | Serial clock pin output value |
| sck_oe | output | 1 | Serial clock pin output enable |
| tx_tick | output | 1 | Transmit clock enable pulse |
| rx_tick | output | 1 | Receive base clock enable pulse |

## Verification
The bench aims at the cases where a counter or divider slips by one:

- **Divisor of zero.** A design that lost the zero case would stall or skip ticks instead of ticking on every cycle.
- **Divisor write mid-count.** A design that ignored the write would finish the old count first.
- **Mode switch mid-count.** A design that kept the old divide phase would emit a transmit tick early or late.
- **Slave clock.** A design with one synchroniser stage too few or too many would move the pulse by a cycle. A design that ignored polarity would fire on the wrong edge.
- **Asynchronous modes.** A design that let `sck_in` through, or drove the pin, would show pulses or an output enable that should not be there.

// File: rtl/sclkg_pkg.sv
package sclkg_pkg;

    typedef enum logic [1:0] {
        MODE_ASYNC_NORM  = 2'd0,
        MODE_ASYNC_DBL   = 2'd1,
        MODE_SYNC_MASTER = 2'd2,
        MODE_SYNC_SLAVE  = 2'd3
    } ck_mode_e;

    function automatic ck_mode_e decode_mode(input logic sync_mode,
                                             input logic dbl_speed,
                                             input logic pin_dir_out);
        if (!sync_mode)
            return dbl_speed ? MODE_ASYNC_DBL : MODE_ASYNC_NORM;
        else
            return pin_dir_out ? MODE_SYNC_MASTER : MODE_SYNC_SLAVE;
    endfunction

endpackage

// File: rtl/sclkg_baud_cnt.sv
module sclkg_baud_cnt #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] divisor,
    input  logic         reload,
    output logic         tick
);

    logic [W-1:0] cnt_q;

    assign tick = (cnt_q == '0);

    // reload on reset, on a divisor write, or on reaching zero
    always_ff @(posedge clk) begin
        if (!rst_n || reload || tick)
            cnt_q <= divisor;
        else
            cnt_q <= cnt_q - 1'b1;
    end

endmodule

// File: rtl/sclkg_txdiv.sv
module sclkg_txdiv #(
    parameter int MAXDIV = 16,
    parameter int DW     = $clog2(MAXDIV)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [DW-1:0] last,
    output logic          wrap,
    output logic          phase
);

    logic [DW-1:0] dc_q;

    assign wrap  = step && (dc_q >= last);
    assign phase = dc_q[0];

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            dc_q <= '0;
        else if (wrap)
            dc_q <= '0;
        else if (step)
            dc_q <= dc_q + 1'b1;
    end

endmodule

// File: rtl/sclkg_edge_det.sv
module sclkg_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic act_fall,
    output logic pulse
);

    // sh_q[0] is the first synchroniser flop; sh_q[STAGES] holds the prior sample
    logic [STAGES:0] sh_q;
    logic            cur;
    logic            prev;

    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_q <= {(STAGES+1){pin}};
        else
            sh_q <= {sh_q[STAGES-1:0], pin};
    end

    assign cur   = sh_q[STAGES-1];
    assign prev  = sh_q[STAGES];
    assign pulse = act_fall ? (!cur && prev) : (cur && !prev);

endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
    import sclkg_pkg::*;
#(
    parameter int DIV_W       = 12,
    parameter int NORM_DIV    = 16,
    parameter int DBL_DIV     = 8,
    parameter int MSTR_DIV    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic             div_lo_wr,
    input  logic             sync_mode,
    input  logic             dbl_speed,
    input  logic             pin_dir_out,
    input  logic             clk_pol,
    input  logic             sck_in,
    output logic             sck_out,
    output logic             sck_oe,
    output logic             tx_tick,
    output logic             rx_tick
);

    localparam int DW = $clog2(NORM_DIV);
    localparam logic [DW-1:0] NORM_LAST = DW'(NORM_DIV - 1);
    localparam logic [DW-1:0] DBL_LAST  = DW'(DBL_DIV - 1);
    localparam logic [DW-1:0] MSTR_LAST = DW'(MSTR_DIV - 1);

    ck_mode_e      mode_q;
    ck_mode_e      mode_d;
    logic          mode_chg;
    logic          gen_tick;
    logic          ext_pulse;
    logic          div_wrap;
    logic          div_phase;
    logic          div_step;
    logic [DW-1:0] div_last;
    logic          use_ext;
    logic          drive_pin;

    // next state: decoded straight from the mode inputs
    always_comb begin
        mode_d = decode_mode(sync_mode, dbl_speed, pin_dir_out);
    end

    // state register; reset and run both load the decoded mode
    always_ff @(posedge clk) begin
        mode_q <= mode_d;
    end

    assign mode_chg = rst_n && (mode_d != mode_q);

    // per-state outputs
    always_comb begin
        div_last  = NORM_LAST;
        use_ext   = 1'b0;
        drive_pin = 1'b0;
        unique case (mode_q)
            MODE_ASYNC_NORM: begin
                div_last = NORM_LAST;
            end
            MODE_ASYNC_DBL: begin
                div_last = DBL_LAST;
            end
            MODE_SYNC_MASTER: begin
                div_last  = MSTR_LAST;
                drive_pin = 1'b1;
            end
            MODE_SYNC_SLAVE: begin
                div_last = MSTR_LAST;
                use_ext  = 1'b1;
            end
        endcase
    end

    sclkg_baud_cnt #(.W(DIV_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (divisor),
        .reload  (div_lo_wr),
        .tick    (gen_tick)
    );

    assign div_step = gen_tick && !use_ext;

    sclkg_txdiv #(.MAXDIV(NORM_DIV), .DW(DW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (mode_chg),
        .step  (div_step),
        .last  (div_last),
        .wrap  (div_wrap),
        .phase (div_phase)
    );

    sclkg_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (sck_in),
        .act_fall (clk_pol),
        .pulse    (ext_pulse)
    );

    assign rx_tick = rst_n && (use_ext ? ext_pulse : gen_tick);
    assign tx_tick = rst_n && (use_ext ? ext_pulse : div_wrap);
    assign sck_oe  = drive_pin;
    assign sck_out = drive_pin ? (div_phase ^ clk_pol) : clk_pol;

endmodule

module sclk_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [11:0] divisor,
    input logic        div_lo_wr,
    input logic        sync_mode,
    input logic        pin_dir_out,
    input logic        clk_pol,
    input logic        sck_out,
    input logic        sck_oe,
    input logic        tx_tick,
    input logic        rx_tick
);

    // R1
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_tick && divisor != 12'd0 && !(sync_mode && !pin_dir_out)
         && !$past(sync_mode && !pin_dir_out)) |=> !rx_tick);

    // R2
    reload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(div_lo_wr) && $past(divisor) != 12'd0
         && !($past(sync_mode) && !$past(pin_dir_out))) |-> !rx_tick);

    // R4
    tx_with_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tick |-> rx_tick);

    // R5
    oe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (sck_oe == ($past(sync_mode) && $past(pin_dir_out))));

    // R6
    slave_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sync_mode) && !$past(pin_dir_out)) |-> (rx_tick == tx_tick));

    // R8
    async_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sync_mode) |-> (!sck_oe && sck_out == clk_pol));

    // R9
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sck_out == clk_pol));

endmodule

bind sclk_gen sclk_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .divisor     (divisor),
    .div_lo_wr   (div_lo_wr),
    .sync_mode   (sync_mode),
    .pin_dir_out (pin_dir_out),
    .clk_pol     (clk_pol),
    .sck_out     (sck_out),
    .sck_oe      (sck_oe),
    .tx_tick     (tx_tick),
    .rx_tick     (rx_tick)
);

// File: tb/sim_sclk_gen.sv
module sim_sclk_gen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] divisor = 12'd0;
    logic        div_lo_wr = 1'b0;
    logic        sync_mode = 1'b0;
    logic        dbl_speed = 1'b0;
    logic        pin_dir_out = 1'b0;
    logic        clk_pol = 1'b0;
    logic        sck_in = 1'b0;
    logic        sck_out, sck_oe, tx_tick, rx_tick;

    int checks = 0;
    int failures = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    // reference state
    int          m_cnt = 0;
    int          m_dc = 0;
    int          m_mode = 0;
    bit          s1, s2, s3;

    always #(CLK_PERIOD/2) clk = ~clk;

    sclk_gen u0 (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .div_lo_wr(div_lo_wr),
        .sync_mode(sync_mode), .dbl_speed(dbl_speed), .pin_dir_out(pin_dir_out),
        .clk_pol(clk_pol), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .tx_tick(tx_tick), .rx_tick(rx_tick)
    );

    // 0 async normal, 1 async double, 2 master, 3 slave
    function automatic int mode_of(bit sy, bit db, bit dr);
        if (!sy) return db ? 1 : 0;
        return dr ? 2 : 3;
    endfunction

    function automatic int factor_of(int md);
        case (md)
            0: return 16;
            1: return 8;
            default: return 2;
        endcase
    endfunction

    task automatic chk(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // reference model update and comparison
    always @(posedge clk) begin
        int nm;
        bit base;
        bit pulse;
        bit e_rx, e_tx, e_oe, e_out;
        nm = mode_of(sync_mode, dbl_speed, pin_dir_out);
        if (!rst_n) begin
            m_cnt = int'(divisor);
            m_dc = 0;
            m_mode = nm;
            s1 = sck_in; s2 = sck_in; s3 = sck_in;
        end else begin
            base = (m_cnt == 0);
            if (nm != m_mode) m_dc = 0;
            else if (base && m_mode != 3)
                m_dc = (m_dc >= factor_of(m_mode) - 1) ? 0 : m_dc + 1;
            m_cnt = (div_lo_wr || base) ? int'(divisor) : m_cnt - 1;
            m_mode = nm;
            s3 = s2; s2 = s1; s1 = sck_in;
        end
        #(CLK_PERIOD/4);
        if (cmp_en && !done) begin
            base  = (m_cnt == 0);
            pulse = clk_pol ? (!s2 && s3) : (s2 && !s3);
            e_rx  = rst_n && ((m_mode == 3) ? pulse : base);
            e_tx  = rst_n && ((m_mode == 3) ? pulse : (base && m_dc == factor_of(m_mode) - 1));
            e_oe  = (m_mode == 2);
            e_out = (m_mode == 2) ? (clk_pol ^ m_dc[0]) : clk_pol;
            chk((m_mode == 3) ? "R6" : "R3", rx_tick, e_rx, "rx_tick");
            chk((m_mode == 3) ? "R6" : "R4", tx_tick, e_tx, "tx_tick");
            chk("R5", sck_oe, e_oe, "sck_oe");
            chk((m_mode == 2) ? "R7" : "R8", sck_out, e_out, "sck_out");
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(bit sy, bit db, bit dr);
        sync_mode = sy; dbl_speed = db; pin_dir_out = dr;
    endtask

    // count tx_tick over 64 cycles with divisor 0, after forcing a mode change
    task automatic tx_count(bit db, bit dr, bit sy, int exp_n, string req);
        int n = 0;
        set_mode(1'b1, 1'b0, 1'b0);
        cyc(3);
        set_mode(sy, db, dr);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (tx_tick) n++;
        end
        chk(req, (n == exp_n), 1'b1, $sformatf("tx count %0d want %0d", n, exp_n));
    endtask

    initial begin
        int hold;
        int gap;
        void'($urandom(32'd20240611));
        divisor = 12'd3;
        set_mode(1'b1, 1'b0, 1'b1);
        clk_pol = 1'b1;
        cyc(1);
        cmp_en = 1'b1;
        cyc(2);
        // R9: reset state
        chk("R9", rx_tick, 1'b0, "rx_tick in reset");
        chk("R9", tx_tick, 1'b0, "tx_tick in reset");
        chk("R9", sck_out, 1'b1, "sck_out idle in reset");
        rst_n = 1'b1;
        cyc(1);
        chk("R9", sck_out, 1'b1, "sck_out idle after release");
        cyc(20);

        // R1: period divisor+1
        set_mode(1'b0, 1'b0, 1'b0);
        divisor = 12'd5;
        hold = 0;
        while (!rx_tick && hold < 100) begin cyc(1); hold++; end
        gap = 0;
        do begin cyc(1); gap++; end while (!rx_tick && gap < 100);
        chk("R1", (gap == 6), 1'b1, $sformatf("tick gap %0d want 6", gap));
        divisor = 12'd0;
        cyc(8);
        for (int i = 0; i < 8; i++) begin
            chk("R1", rx_tick, 1'b1, "divisor 0 ticks every cycle");
            cyc(1);
        end

        // R2: divisor write reloads at once
        divisor = 12'd40;
        cyc(50);
        divisor = 12'd3;
        div_lo_wr = 1'b1;
        cyc(1);
        div_lo_wr = 1'b0;
        chk("R2", rx_tick, 1'b0, "no tick 1 after reload");
        cyc(1);
        chk("R2", rx_tick, 1'b0, "no tick 2 after reload");
        cyc(1);
        chk("R2", rx_tick, 1'b0, "no tick 3 after reload");
        cyc(1);
        chk("R2", rx_tick, 1'b1, "tick 4 after reload");

        // R4 / R5: divide factors, counted from a mode change
        divisor = 12'd0;
        tx_count(1'b0, 1'b0, 1'b0, 4, "R4");
        tx_count(1'b1, 1'b0, 1'b0, 8, "R4");
        tx_count(1'b0, 1'b1, 1'b1, 32, "R5");

        // R6: slave pulse timing and polarity
        set_mode(1'b1, 1'b0, 1'b0);
        clk_pol = 1'b0;
        sck_in = 1'b0;
        cyc(5);
        sck_in = 1'b1;
        cyc(1);
        chk("R6", rx_tick, 1'b0, "no pulse one cycle after rise");
        cyc(1);
        chk("R6", rx_tick, 1'b1, "pulse after rise");
        cyc(1);
        chk("R6", rx_tick, 1'b0, "single-cycle pulse");
        cyc(3);
        sck_in = 1'b0;
        cyc(2);
        chk("R6", rx_tick, 1'b0, "fall inactive with pol 0");

        // R8: asynchronous mode ignores the pin
        set_mode(1'b0, 1'b1, 1'b1);
        divisor = 12'd9;
        for (int i = 0; i < 40; i++) begin
            sck_in = ~sck_in;
            cyc(1);
            chk("R8", sck_oe, 1'b0, "pin not driven in async");
        end

        // random phase
        for (int seg = 0; seg < 30; seg++) begin
            set_mode(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
            clk_pol = 1'($urandom % 2);
            divisor = 12'($urandom % 24);
            hold = 3;
            for (int i = 0; i < 300; i++) begin
                div_lo_wr = ($urandom % 40 == 0);
                if (hold == 0) begin
                    sck_in = ~sck_in;
                    hold = 3 + int'($urandom % 7);
                end else hold--;
                if ($urandom % 200 == 0) divisor = 12'($urandom % 24);
                cyc(1);
            end
            div_lo_wr = 1'b0;
        end

        // R9: mid-run reset
        rst_n = 1'b0;
        set_mode(1'b1, 1'b0, 1'b1);
        cyc(2);
        chk("R9", tx_tick, 1'b0, "tx_tick in second reset");
        rst_n = 1'b1;
        cyc(30);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule